// File: doc/BRIEF.md
# Five-Stage Pipelined Subset Processor

This block is a small in-order processor core with fetch, decode, execute, memory and write-back stages. It runs a nine-operation integer subset: three register-register operations (add, bitwise or, signed set-less-than), subtract-immediate, word load and store, branch-if-equal, branch-if-not-equal and an absolute jump. Instructions come from a private 16-word instruction store. Data lives in a separate 16-word data store. There are sixteen 32-bit registers. Both stores are word addressed, and every access to either one completes in one cycle.

The decoder builds the control word for each instruction and sends it down the pipe with that instruction. The execute stage takes operands forwarded from the two older stages. A load followed at once by a consumer of its result costs one stall cycle. Fetch always assumes a branch is not taken. Both branches and the jump are resolved in execute, and when the flow changes the two younger instructions are squashed. The instruction store is filled through a write port that the surrounding system or a test drives.

Every register write is reported on a retire stream, and debug pins show the PC, the opcode in each stage and a cycle count. The retire stream carries valid only and has no back-pressure. A reported write is visible for exactly one cycle, and the consumer must take it in that cycle.

Top module: `pipe5_core`

## Requirements
- R1: While reset is low the PC is 0, the cycle count is 0, retire_valid is low, and the decode, execute, memory and write-back stages hold bubbles (opcode 0). The first fetch after reset is from address 0.
- R2: An instruction word has the opcode in bits 31:28, rd in 27:24, rs in 23:20, rt in 19:16 and a signed 16-bit immediate in 15:0. The opcodes are: 0 no-op, 1 add, 2 subtract-immediate, 3 or, 4 load, 5 store, 6 branch-equal, 7 branch-not-equal, 8 jump, 9 set-less-than. Codes 10 to 15 act as no-ops.
- R3: Add gives rd=rs+rt. Or gives rd=rs|rt. Set-less-than writes 1 to rd when rs<rt as signed values and 0 otherwise. Subtract-immediate gives rd=rs minus the immediate sign-extended to 32 bits.
- R4: Register 0 always reads as 0. A write aimed at it is dropped, is never forwarded and never appears on the retire stream.
- R5: Load gives rd=dmem[a] and store gives dmem[a]=rt, where a is the low 4 bits of rs plus the sign-extended immediate. The data store is separate from the instruction store.
- R6: An execute-stage operand takes the result of the instruction one ahead or two ahead of it. When both of those write the same register, the one closer to execute wins. A write-back in the same cycle is seen by the instruction being decoded.
- R7: When the instruction in decode reads the destination of a load that is in execute, the PC and the decode stage hold for one cycle and a bubble enters execute. No other case stalls.
- R8: When there is no stall or redirect, the PC advances by one word each cycle and wraps modulo 16.
- R9: Branch-equal and branch-not-equal compare rs with rt in execute. When taken, the next fetch is from (branch address + 1 + immediate) mod 16, and the instructions in decode and fetch become bubbles. A branch that is not taken costs no cycle.
- R10: Jump goes to the absolute address in bits 3:0. It is resolved in execute with the same two-slot squash.
- R11: Each register write raises retire_valid for one cycle at write-back, with the register number and value, in program order. The stream has no ready signal.
- R12: dbg_cycles counts clock edges since reset was released. dbg_pc is the fetch address. dbg_stage_ops packs the opcodes of fetch, decode, execute, memory and write-back from bit 19 down to bit 0, four bits each.
- R13: When prog_we is high at a rising edge, prog_data is written to instruction address prog_addr. This works whether or not reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | IAW | Instruction store write address |
| prog_data | input | 32 | Instruction word to store |
| retire_valid | output | 1 | A register write retires this cycle |
| retire_reg | output | 4 | Destination register of the retiring write |
| retire_data | output | 32 | Value written |
| dbg_pc | output | IAW | Current fetch address |
| dbg_stage_ops | output | 20 | Opcodes of fetch, decode, execute, memory and write-back |
| dbg_cycles | output | CNT_W | Cycles since reset release |

## Verification
Two events can fall in the same execute cycle: a branch comparison is made, and the operands it compares arrive by forwarding from the memory and write-back stages. The test provokes this by placing a branch directly after two register writes that produce its operands. It judges the outcome by the exact cycle count at which the next retired write appears. Forward priority is provoked the same way, with two consecutive writes to one register followed by a reader, and it is judged by the value that retires.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN = 32;
  localparam int RAW  = 4;
  localparam int OPW  = 4;
  localparam int IMMW = 16;
  localparam int OP_HI = XLEN - 1;
  localparam int RD_HI = XLEN - OPW - 1;
  localparam int RS_HI = RD_HI - RAW;
  localparam int RT_HI = RS_HI - RAW;

  localparam logic [OPW-1:0] OP_NOP  = 4'd0;
  localparam logic [OPW-1:0] OP_ADD  = 4'd1;
  localparam logic [OPW-1:0] OP_SUBI = 4'd2;
  localparam logic [OPW-1:0] OP_OR   = 4'd3;
  localparam logic [OPW-1:0] OP_LW   = 4'd4;
  localparam logic [OPW-1:0] OP_SW   = 4'd5;
  localparam logic [OPW-1:0] OP_BEQ  = 4'd6;
  localparam logic [OPW-1:0] OP_BNE  = 4'd7;
  localparam logic [OPW-1:0] OP_J    = 4'd8;
  localparam logic [OPW-1:0] OP_SLT  = 4'd9;

  typedef struct packed {
    logic [OPW-1:0]  op;
    logic [RAW-1:0]  rd;
    logic [RAW-1:0]  rs;
    logic [RAW-1:0]  rt;
    logic [XLEN-1:0] imm;
    logic            reg_we;
    logic            mem_rd;
    logic            mem_wr;
    logic            use_rs;
    logic            use_rt;
    logic            br_eq;
    logic            br_ne;
    logic            jump;
  } ctrl_t;
endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctrl
);
  logic [OPW-1:0] opc;
  assign opc = instr[OP_HI -: OPW];

  always_comb begin
    ctrl     = '0;
    ctrl.rd  = instr[RD_HI -: RAW];
    ctrl.rs  = instr[RS_HI -: RAW];
    ctrl.rt  = instr[RT_HI -: RAW];
    ctrl.imm = {{(XLEN-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};
    case (opc)
      OP_ADD, OP_OR, OP_SLT: begin
        ctrl.op = opc; ctrl.reg_we = 1'b1; ctrl.use_rs = 1'b1; ctrl.use_rt = 1'b1;
      end
      OP_SUBI: begin
        ctrl.op = opc; ctrl.reg_we = 1'b1; ctrl.use_rs = 1'b1;
      end
      OP_LW: begin
        ctrl.op = opc; ctrl.reg_we = 1'b1; ctrl.mem_rd = 1'b1; ctrl.use_rs = 1'b1;
      end
      OP_SW: begin
        ctrl.op = opc; ctrl.mem_wr = 1'b1; ctrl.use_rs = 1'b1; ctrl.use_rt = 1'b1;
      end
      OP_BEQ: begin
        ctrl.op = opc; ctrl.br_eq = 1'b1; ctrl.use_rs = 1'b1; ctrl.use_rt = 1'b1;
      end
      OP_BNE: begin
        ctrl.op = opc; ctrl.br_ne = 1'b1; ctrl.use_rs = 1'b1; ctrl.use_rt = 1'b1;
      end
      OP_J: begin
        ctrl.op = opc; ctrl.jump = 1'b1;
      end
      default: ;
    endcase
    if (ctrl.rd == '0) ctrl.reg_we = 1'b0;
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int AW = 4,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [W-1:0]  rd_data_a,
  output logic [W-1:0]  rd_data_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data
);
  localparam int NREG = 1 << AW;
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en && wr_addr != '0) begin
      regs[wr_addr] <= wr_data;
    end
  end

  assign rd_data_a = (rd_addr_a == '0) ? '0 :
                     (wr_en && wr_addr == rd_addr_a) ? wr_data : regs[rd_addr_a];
  assign rd_data_b = (rd_addr_b == '0) ? '0 :
                     (wr_en && wr_addr == rd_addr_b) ? wr_data : regs[rd_addr_b];
endmodule

// File: rtl/pipe5_exec.sv
module pipe5_exec
  import pipe5_pkg::*;
#(
  parameter int PCW = 4
) (
  input  ctrl_t           ctrl,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [PCW-1:0]  pc,
  output logic [XLEN-1:0] result,
  output logic            taken,
  output logic [PCW-1:0]  target
);
  always_comb begin
    case (ctrl.op)
      OP_ADD:       result = opa + opb;
      OP_SUBI:      result = opa - ctrl.imm;
      OP_OR:        result = opa | opb;
      OP_SLT:       result = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(opb))};
      OP_LW, OP_SW: result = opa + ctrl.imm;
      default:      result = '0;
    endcase
  end

  assign taken  = (ctrl.br_eq && opa == opb) || (ctrl.br_ne && opa != opb) || ctrl.jump;
  assign target = ctrl.jump ? ctrl.imm[PCW-1:0] : pc + PCW'(1) + ctrl.imm[PCW-1:0];
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IAW   = 4,
  parameter int DAW   = 4,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_we,
  input  logic [IAW-1:0]   prog_addr,
  input  logic [XLEN-1:0]  prog_data,
  output logic             retire_valid,
  output logic [RAW-1:0]   retire_reg,
  output logic [XLEN-1:0]  retire_data,
  output logic [IAW-1:0]   dbg_pc,
  output logic [5*OPW-1:0] dbg_stage_ops,
  output logic [CNT_W-1:0] dbg_cycles
);
  localparam int PCW    = IAW;
  localparam int IDEPTH = 1 << IAW;
  localparam int DDEPTH = 1 << DAW;

  // fetch
  logic [XLEN-1:0] imem [IDEPTH];
  logic [PCW-1:0]  pc_q;
  logic [XLEN-1:0] if_word;

  always_ff @(posedge clk) begin
    if (prog_we) imem[prog_addr] <= prog_data;
  end
  assign if_word = imem[pc_q];

  // decode
  logic [XLEN-1:0] id_word;
  logic [PCW-1:0]  id_pc;
  ctrl_t           id_c;
  logic [XLEN-1:0] id_va, id_vb;

  // execute
  ctrl_t           ex_c;
  logic [XLEN-1:0] ex_va, ex_vb;
  logic [PCW-1:0]  ex_pc;
  logic [XLEN-1:0] ex_res;
  logic [XLEN-1:0] ex_opd [2];
  logic            ex_redirect;
  logic [PCW-1:0]  ex_target;
  logic            ld_stall;

  // memory
  logic [OPW-1:0]  mem_op;
  logic            mem_we, mem_ld, mem_st;
  logic [RAW-1:0]  mem_rd;
  logic [XLEN-1:0] mem_res, mem_sdata, mem_val;
  logic [XLEN-1:0] dmem [DDEPTH];

  // write-back
  logic [OPW-1:0]  wb_op;
  logic            wb_we;
  logic [RAW-1:0]  wb_rd;
  logic [XLEN-1:0] wb_data;

  pipe5_decode u_dec (.instr(id_word), .ctrl(id_c));

  pipe5_regfile #(.AW(RAW), .W(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(id_c.rs), .rd_addr_b(id_c.rt),
    .rd_data_a(id_va), .rd_data_b(id_vb),
    .wr_en(wb_we), .wr_addr(wb_rd), .wr_data(wb_data)
  );

  // operand forwarding: memory-stage result beats write-back result
  generate
    for (genvar k = 0; k < 2; k++) begin : g_fwd
      logic [RAW-1:0]  src;
      logic            used;
      logic [XLEN-1:0] raw;
      assign src  = (k == 0) ? ex_c.rs : ex_c.rt;
      assign used = (k == 0) ? ex_c.use_rs : ex_c.use_rt;
      assign raw  = (k == 0) ? ex_va : ex_vb;
      always_comb begin
        if (used && mem_we && !mem_ld && mem_rd == src)  ex_opd[k] = mem_res;
        else if (used && wb_we && wb_rd == src)          ex_opd[k] = wb_data;
        else                                             ex_opd[k] = raw;
      end
    end
  endgenerate

  pipe5_exec #(.PCW(PCW)) u_ex (
    .ctrl(ex_c), .opa(ex_opd[0]), .opb(ex_opd[1]), .pc(ex_pc),
    .result(ex_res), .taken(ex_redirect), .target(ex_target)
  );

  assign ld_stall = ex_c.mem_rd && ex_c.reg_we &&
                    ((id_c.use_rs && id_c.rs == ex_c.rd) ||
                     (id_c.use_rt && id_c.rt == ex_c.rd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      id_word <= '0;
      id_pc   <= '0;
    end else if (ex_redirect) begin
      pc_q    <= ex_target;
      id_word <= '0;
    end else if (!ld_stall) begin
      pc_q    <= pc_q + PCW'(1);
      id_word <= if_word;
      id_pc   <= pc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_c  <= '0;
      ex_va <= '0;
      ex_vb <= '0;
      ex_pc <= '0;
    end else if (ex_redirect || ld_stall) begin
      ex_c  <= '0;
    end else begin
      ex_c  <= id_c;
      ex_va <= id_va;
      ex_vb <= id_vb;
      ex_pc <= id_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_op <= '0; mem_we <= 1'b0; mem_ld <= 1'b0; mem_st <= 1'b0;
      mem_rd <= '0; mem_res <= '0; mem_sdata <= '0;
    end else begin
      mem_op    <= ex_c.op;
      mem_we    <= ex_c.reg_we;
      mem_ld    <= ex_c.mem_rd;
      mem_st    <= ex_c.mem_wr;
      mem_rd    <= ex_c.rd;
      mem_res   <= ex_res;
      mem_sdata <= ex_opd[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DDEPTH; i++) dmem[i] <= '0;
    end else if (mem_st) begin
      dmem[mem_res[DAW-1:0]] <= mem_sdata;
    end
  end
  assign mem_val = mem_ld ? dmem[mem_res[DAW-1:0]] : mem_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_op <= '0; wb_we <= 1'b0; wb_rd <= '0; wb_data <= '0;
    end else begin
      wb_op   <= mem_op;
      wb_we   <= mem_we;
      wb_rd   <= mem_rd;
      wb_data <= mem_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_cycles <= '0;
    else        dbg_cycles <= dbg_cycles + CNT_W'(1);
  end

  assign retire_valid  = wb_we;
  assign retire_reg    = wb_rd;
  assign retire_data   = wb_data;
  assign dbg_pc        = pc_q;
  assign dbg_stage_ops = {if_word[OP_HI -: OPW], id_c.op, ex_c.op, mem_op, wb_op};
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk #(
  parameter int PCW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [PCW-1:0] pc,
  input logic           redirect,
  input logic           stall,
  input logic [19:0]    stage_ops,
  input logic           retire_valid,
  input logic [3:0]     retire_reg
);
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect && !stall) |=> pc == $past(pc) + PCW'(1)); // R8

  AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !redirect) |=> pc == $past(pc)); // R7

  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> stage_ops[11:8] == 4'd0); // R7

  AST_FLUSH_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (stage_ops[15:12] == 4'd0 && stage_ops[11:8] == 4'd0)); // R9

  AST_NO_R0_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> retire_reg != 4'd0); // R4
endmodule

bind pipe5_core pipe5_core_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc(dbg_pc), .redirect(ex_redirect),
  .stall(ld_stall), .stage_ops(dbg_stage_ops),
  .retire_valid(retire_valid), .retire_reg(retire_reg)
);

// File: tb/pipe5_core_bench.sv
`timescale 1ns/1ps
module pipe5_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [3:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic        retire_valid;
  logic [3:0]  retire_reg;
  logic [31:0] retire_data;
  logic [3:0]  dbg_pc;
  logic [19:0] dbg_stage_ops;
  logic [31:0] dbg_cycles;

  always #2 clk = ~clk;

  pipe5_core u_pipe5_core (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .retire_valid(retire_valid), .retire_reg(retire_reg),
    .retire_data(retire_data), .dbg_pc(dbg_pc), .dbg_stage_ops(dbg_stage_ops),
    .dbg_cycles(dbg_cycles)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int unsigned q_reg[$];
  logic [31:0] q_data[$];
  int unsigned q_cnt[$];
  string       q_tag[$];

  task automatic check(input bit ok, input string msg);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  // R2 field layout: op[31:28] rd[27:24] rs[23:20] rt[19:16] imm[15:0]
  function automatic logic [31:0] enc(input int op, input int rd, input int rs,
                                      input int rt, input int imm);
    logic [15:0] i16;
    i16 = 16'(imm);
    return {4'(op), 4'(rd), 4'(rs), 4'(rt), i16};
  endfunction

  task automatic push(input int unsigned r, input logic [31:0] d,
                      input int unsigned c, input string tag);
    q_reg.push_back(r); q_data.push_back(d); q_cnt.push_back(c); q_tag.push_back(tag);
  endtask

  task automatic load(input int a, input logic [31:0] w);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 4'(a); prog_data = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  // monitor: scoreboard pops expected retires
  always @(negedge clk) begin
    if (rst_n && retire_valid) begin
      if (q_reg.size() == 0) begin
        check(1'b0, $sformatf("R11 unexpected retire: actual r%0d=%h, expected none",
                              retire_reg, retire_data));
      end else begin
        int unsigned er, ec;
        logic [31:0] ed;
        string et;
        er = q_reg.pop_front(); ed = q_data.pop_front();
        ec = q_cnt.pop_front(); et = q_tag.pop_front();
        check(retire_reg == 4'(er) && retire_data == ed && dbg_cycles == ec,
              $sformatf("%s retire: actual r%0d=%h @%0d, expected r%0d=%h @%0d",
                        et, retire_reg, retire_data, dbg_cycles, er, ed, ec));
      end
    end
  end

  task automatic reset_checks(input int first_op);
    check(dbg_pc == 4'd0, $sformatf("R1 pc: actual %0d, expected 0", dbg_pc));
    check(dbg_stage_ops[15:0] == 16'h0,
          $sformatf("R1 stage ops: actual %h, expected 0000", dbg_stage_ops[15:0]));
    check(dbg_cycles == 0, $sformatf("R1 cycles: actual %0d, expected 0", dbg_cycles));
    check(!retire_valid, $sformatf("R1 retire_valid: actual %0d, expected 0", retire_valid));
    check(dbg_stage_ops[19:16] == 4'(first_op),
          $sformatf("R13 fetch opcode after preload: actual %0d, expected %0d",
                    dbg_stage_ops[19:16], first_op));
  endtask

  task automatic run_and_drain(input string name);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check(q_reg.size() == 0, $sformatf("R11 %s pending retires: actual %0d, expected 0",
                                       name, q_reg.size()));
    check(dbg_cycles == 40, $sformatf("R12 %s cycles: actual %0d, expected 40",
                                      name, dbg_cycles));
  endtask

  initial begin
    // Program A: arithmetic, forwarding, memory, load-use, register 0
    load(0,  enc(2, 1, 0, 0, -5));   // r1 = 5
    load(1,  enc(2, 2, 0, 0, 3));    // r2 = -3
    load(2,  enc(1, 3, 1, 2, 0));    // r3 = 2
    load(3,  enc(9, 4, 2, 1, 0));    // r4 = 1
    load(4,  enc(3, 5, 3, 4, 0));    // r5 = 3
    load(5,  enc(5, 0, 0, 5, 7));    // dmem[7] = 3
    load(6,  enc(4, 6, 0, 0, 7));    // r6 = 3
    load(7,  enc(1, 7, 6, 6, 0));    // r7 = 6, one stall
    load(8,  enc(1, 0, 1, 1, 0));    // write to r0 dropped
    load(9,  enc(1, 8, 0, 1, 0));    // r8 = 5
    load(10, enc(2, 9, 0, 0, -1));   // r9 = 1
    load(11, enc(2, 9, 9, 0, -1));   // r9 = 2
    load(12, enc(1, 10, 9, 0, 0));   // r10 = 2 (younger producer wins)
    load(13, enc(4, 11, 1, 0, 18));  // r11 = dmem[(5+18)&15] = 3
    load(14, enc(9, 12, 1, 2, 0));   // r12 = 0
    load(15, enc(8, 0, 0, 0, 15));   // halt loop
    @(negedge clk);
    reset_checks(2);

    push(1,  32'd5,        4,  "R3");
    push(2,  32'hFFFFFFFD, 5,  "R3");
    push(3,  32'd2,        6,  "R6");
    push(4,  32'd1,        7,  "R3");
    push(5,  32'd3,        8,  "R3");
    push(6,  32'd3,        10, "R5");
    push(7,  32'd6,        12, "R7");
    push(8,  32'd5,        14, "R4");
    push(9,  32'd1,        15, "R8");
    push(9,  32'd2,        16, "R6");
    push(10, 32'd2,        17, "R6");
    push(11, 32'd3,        18, "R5");
    push(12, 32'd0,        19, "R3");
    run_and_drain("A");

    // Program B: branches and jump
    rst_n = 1'b0;
    load(0,  enc(2, 1, 0, 0, -4));   // r1 = 4
    load(1,  enc(2, 2, 0, 0, -4));   // r2 = 4
    load(2,  enc(6, 0, 1, 2, 2));    // taken -> 5
    load(3,  enc(2, 3, 0, 0, -1));   // squashed
    load(4,  enc(2, 4, 0, 0, -1));   // squashed
    load(5,  enc(7, 0, 1, 2, 5));    // not taken
    load(6,  enc(2, 5, 0, 0, -7));   // r5 = 7
    load(7,  enc(7, 0, 5, 1, 1));    // taken -> 9
    load(8,  enc(2, 6, 0, 0, -1));   // squashed
    load(9,  enc(6, 0, 5, 1, 3));    // not taken
    load(10, enc(2, 7, 0, 0, -9));   // r7 = 9
    load(11, enc(8, 0, 0, 0, 13));   // jump -> 13
    load(12, enc(2, 8, 0, 0, -1));   // squashed
    load(13, enc(2, 8, 0, 0, -2));   // r8 = 2
    load(14, enc(6, 0, 0, 0, -1));   // self loop
    load(15, enc(2, 9, 0, 0, -1));   // squashed
    @(negedge clk);
    reset_checks(2);

    push(1, 32'd4, 4,  "R8");
    push(2, 32'd4, 5,  "R8");
    push(5, 32'd7, 10, "R9");
    push(7, 32'd9, 15, "R9");
    push(8, 32'd2, 19, "R10");
    run_and_drain("B");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired: actual running, expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule